// File: doc/BRIEF.md
# Power-Gated Issue Queue Wakeup Array

This block is the wakeup half of an out-of-order issue queue. It holds a small set of waiting instructions. Each instruction has two source operand tags, one ready flag per operand and a valid flag. Every cycle up to W result tags are broadcast, and each tag has its own slot-valid qualifier. A waiting operand compares its tag against every qualified broadcast tag and ORs the hits into its ready flag. An entry whose two operands are both ready raises its issue request.

Most comparisons in a real queue miss, so the array switches a comparator only when it can do useful work. The entry must be valid, the operand must not yet be ready, and the broadcast slot must be qualified. The block exposes which operands currently have their comparators switched on. It also gives the number of tag comparisons enabled in the current cycle, so that an activity-based power estimate can be formed.

An allocation port loads a chosen entry. A clear port frees an entry once it has issued. A result broadcast in the same cycle as an allocation is matched against the incoming tags, so a wakeup that lands in that cycle is not lost.

Top module: `iq_wakeup_gated`

## Requirements
- R1: After reset every entry is invalid, so `iss_req`, `cmp_on` and `cmp_count` are all zero.
- R2: When `ins_en` is high, entry `ins_slot` takes `ins_tag_a`/`ins_tag_b` and the initial ready flags `ins_rdy_a`/`ins_rdy_b` at the clock edge, and becomes valid.
- R3: For a valid entry whose operand is not ready, a broadcast slot i with `res_vld[i]`=1 and tag `res_tag[i*TAGW +: TAGW]` equal to the operand tag sets that operand ready at the next edge. Every slot can cause the wakeup.
- R4: A broadcast slot whose `res_vld` bit is 0 wakes nothing and adds nothing to `cmp_count`.
- R5: `iss_req[e]` is 1 exactly when entry e is valid and both of its operands are ready.
- R6: `cmp_on[2*e+s]` (s=0 for operand A, s=1 for operand B) is 1 exactly when entry e is valid and that operand is not ready.
- R7: `cmp_count` equals the number of (operand, broadcast slot) pairs in the current cycle where the operand's `cmp_on` bit is 1 and the slot's `res_vld` bit is 1.
- R8: If a qualified broadcast tag equals an incoming allocation tag in the cycle of the allocation, that operand is stored as ready.
- R9: `rel_en` with `rel_slot` makes that entry invalid at the next edge. If the same entry is allocated in the same cycle, the allocation wins.
- R10: A ready operand stays ready, whatever is broadcast, until its entry is allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Allocate an entry this cycle |
| ins_slot | input | $clog2(ENTRIES) | Entry index to allocate |
| ins_tag_a | input | TAGW | Source tag of operand A |
| ins_tag_b | input | TAGW | Source tag of operand B |
| ins_rdy_a | input | 1 | Operand A already available |
| ins_rdy_b | input | 1 | Operand B already available |
| rel_en | input | 1 | Free an entry this cycle |
| rel_slot | input | $clog2(ENTRIES) | Entry index to free |
| res_vld | input | W | Per-slot broadcast qualifier |
| res_tag | input | W*TAGW | Broadcast result tags, slot i at bits i*TAGW |
| iss_req | output | ENTRIES | Entry valid with both operands ready |
| cmp_on | output | 2*ENTRIES | Per-operand comparator enable |
| cmp_count | output | $clog2(2*ENTRIES*W+1) | Tag comparisons enabled this cycle |

## Verification
Two collisions matter most. The first is an allocation and a matching broadcast in the same cycle. The bench allocates an entry while both broadcast slots carry its two tags, then expects a request one cycle later and no comparator enabled for that entry. The second is a clear and an allocation aimed at one entry in the same cycle. The bench expects the entry to stay valid with the new tags and with both operands waiting, and it confirms this through `cmp_on`, `cmp_count` and a later wakeup.

// File: rtl/iq_wake_pkg.sv
package iq_wake_pkg;
  localparam int SRCS = 2;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int W    = 2,
  parameter int TAGW = 6
) (
  input  logic [TAGW-1:0]   opnd_tag,
  input  logic              opnd_wait,
  input  logic [W-1:0]      res_vld,
  input  logic [W*TAGW-1:0] res_tag,
  output logic [W-1:0]      pair_on,
  output logic              hit
);
  logic [W-1:0] slot_hit;

  for (genvar i = 0; i < W; i++) begin : g_slot
    assign pair_on[i]  = opnd_wait & res_vld[i];
    assign slot_hit[i] = pair_on[i] && (res_tag[i*TAGW +: TAGW] == opnd_tag);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_wake_pkg::*;
#(
  parameter int W    = 2,
  parameter int TAGW = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [SRCS-1:0][TAGW-1:0]  load_tag,
  input  logic [SRCS-1:0]            load_rdy,
  input  logic                       drop,
  input  logic [W-1:0]               res_vld,
  input  logic [W*TAGW-1:0]          res_tag,
  output logic                       req,
  output logic [SRCS-1:0]            opnd_on,
  output logic [SRCS*W-1:0]          pair_on
);
  logic                      valid_q, valid_d;
  logic [SRCS-1:0]           rdy_q, rdy_d;
  logic [SRCS-1:0][TAGW-1:0] tag_q;
  logic [SRCS-1:0]           hit;
  logic [SRCS-1:0]           byp_hit;

  for (genvar s = 0; s < SRCS; s++) begin : g_src
    assign opnd_on[s] = valid_q & ~rdy_q[s];
    iq_tag_match #(.W(W), .TAGW(TAGW)) match_i (
      .opnd_tag (tag_q[s]),
      .opnd_wait(opnd_on[s]),
      .res_vld  (res_vld),
      .res_tag  (res_tag),
      .pair_on  (pair_on[s*W +: W]),
      .hit      (hit[s])
    );
  end

  // same-cycle bypass: incoming tags against the current broadcast
  always_comb begin
    byp_hit = '0;
    for (int s = 0; s < SRCS; s++) begin
      for (int i = 0; i < W; i++) begin
        if (load && !load_rdy[s] && res_vld[i] &&
            (res_tag[i*TAGW +: TAGW] == load_tag[s]))
          byp_hit[s] = 1'b1;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    rdy_d   = rdy_q | hit;
    if (load) begin
      valid_d = 1'b1;
      rdy_d   = load_rdy | byp_hit;
    end else if (drop) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
    end else begin
      valid_q <= valid_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) tag_q <= load_tag;
  end

  assign req = valid_q & (&rdy_q);
endmodule

// File: rtl/iq_popcount.sv
module iq_popcount #(
  parameter int N  = 32,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(vec[i]);
  end
endmodule

// File: rtl/iq_wakeup_gated.sv
module iq_wakeup_gated
  import iq_wake_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int W       = 2,
  parameter int TAGW    = 6,
  localparam int IDXW   = $clog2(ENTRIES),
  localparam int PAIRS  = ENTRIES * SRCS * W,
  localparam int CNTW   = $clog2(PAIRS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_en,
  input  logic [IDXW-1:0]          ins_slot,
  input  logic [TAGW-1:0]          ins_tag_a,
  input  logic [TAGW-1:0]          ins_tag_b,
  input  logic                     ins_rdy_a,
  input  logic                     ins_rdy_b,
  input  logic                     rel_en,
  input  logic [IDXW-1:0]          rel_slot,
  input  logic [W-1:0]             res_vld,
  input  logic [W*TAGW-1:0]        res_tag,
  output logic [ENTRIES-1:0]       iss_req,
  output logic [SRCS*ENTRIES-1:0]  cmp_on,
  output logic [CNTW-1:0]          cmp_count
);
  logic [SRCS-1:0][TAGW-1:0] ins_tags;
  logic [SRCS-1:0]           ins_rdys;
  logic [PAIRS-1:0]          pair_on;

  assign ins_tags[SRC_A] = ins_tag_a;
  assign ins_tags[SRC_B] = ins_tag_b;
  assign ins_rdys[SRC_A] = ins_rdy_a;
  assign ins_rdys[SRC_B] = ins_rdy_b;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic load_e, drop_e;
    assign load_e = ins_en && (ins_slot == IDXW'(e));
    assign drop_e = rel_en && (rel_slot == IDXW'(e));
    iq_entry #(.W(W), .TAGW(TAGW)) ent_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_e),
      .load_tag(ins_tags),
      .load_rdy(ins_rdys),
      .drop    (drop_e),
      .res_vld (res_vld),
      .res_tag (res_tag),
      .req     (iss_req[e]),
      .opnd_on (cmp_on[e*SRCS +: SRCS]),
      .pair_on (pair_on[e*SRCS*W +: SRCS*W])
    );
  end

  iq_popcount #(.N(PAIRS), .CW(CNTW)) cnt_i (
    .vec  (pair_on),
    .count(cmp_count)
  );
endmodule

// File: rtl/iq_wakeup_gated_chk.sv
module iq_wakeup_gated_chk #(
  parameter int ENTRIES = 8,
  parameter int W       = 2,
  parameter int IDXW    = 3,
  parameter int CNTW    = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ins_en,
  input logic [IDXW-1:0]         ins_slot,
  input logic                    rel_en,
  input logic [IDXW-1:0]         rel_slot,
  input logic [W-1:0]            res_vld,
  input logic [ENTRIES-1:0]      iss_req,
  input logic [2*ENTRIES-1:0]    cmp_on,
  input logic [CNTW-1:0]         cmp_count
);
  a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cmp_count) == $countones(cmp_on) * $countones(res_vld));

  a_r4_idle_slots_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld == '0) |-> (cmp_count == '0));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_e
    a_r5_req_no_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      iss_req[e] |-> (cmp_on[2*e +: 2] == 2'b00));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_en && rel_slot == IDXW'(e) && !(ins_en && ins_slot == IDXW'(e)))
      |=> (!iss_req[e] && cmp_on[2*e +: 2] == 2'b00));

    for (genvar s = 0; s < 2; s++) begin : g_s
      a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_on[2*e+s]) |-> $past(ins_en && ins_slot == IDXW'(e)));
    end
  end
endmodule

bind iq_wakeup_gated iq_wakeup_gated_chk #(
  .ENTRIES(ENTRIES), .W(W), .IDXW(IDXW), .CNTW(CNTW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_slot(ins_slot),
  .rel_en(rel_en), .rel_slot(rel_slot), .res_vld(res_vld),
  .iss_req(iss_req), .cmp_on(cmp_on), .cmp_count(cmp_count)
);

// File: tb/iq_wakeup_gated_tb.sv
module iq_wakeup_gated_tb_top;
  localparam int ENTRIES = 8;
  localparam int W       = 2;
  localparam int TAGW    = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ins_en, ins_rdy_a, ins_rdy_b, rel_en;
  logic [2:0]        ins_slot, rel_slot;
  logic [TAGW-1:0]   ins_tag_a, ins_tag_b;
  logic [W-1:0]      res_vld;
  logic [W*TAGW-1:0] res_tag;
  logic [7:0]        iss_req;
  logic [15:0]       cmp_on;
  logic [5:0]        cmp_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  iq_wakeup_gated dut_i (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_slot(ins_slot),
    .ins_tag_a(ins_tag_a), .ins_tag_b(ins_tag_b), .ins_rdy_a(ins_rdy_a),
    .ins_rdy_b(ins_rdy_b), .rel_en(rel_en), .rel_slot(rel_slot),
    .res_vld(res_vld), .res_tag(res_tag), .iss_req(iss_req),
    .cmp_on(cmp_on), .cmp_count(cmp_count)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    ins_en = 0; ins_slot = 0; ins_tag_a = 0; ins_tag_b = 0;
    ins_rdy_a = 0; ins_rdy_b = 0; rel_en = 0; rel_slot = 0;
    res_vld = 0; res_tag = 0;
  endtask

  // inputs change at the falling edge; outputs are read 2 ns later
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
    #2;
  endtask

  task automatic alloc(input int e, input int ta, input int tb, input bit ra, input bit rb);
    ins_en = 1; ins_slot = 3'(e); ins_tag_a = TAGW'(ta); ins_tag_b = TAGW'(tb);
    ins_rdy_a = ra; ins_rdy_b = rb;
  endtask

  task automatic bcast(input logic [1:0] v, input int t0, input int t1);
    res_vld = v; res_tag = {TAGW'(t1), TAGW'(t0)};
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1; #2;
    chk("R1 req", 32'(iss_req), 0);
    chk("R1 cmp_on", 32'(cmp_on), 0);
    chk("R1 count", 32'(cmp_count), 0);
  endtask

  task automatic t_wakeup();
    alloc(3, 5, 9, 0, 0);
    tick();
    chk("R2/R6 entry3 both waiting", 32'(cmp_on), 32'h00C0);
    chk("R5 no req yet", 32'(iss_req), 0);
    bcast(2'b01, 5, 0);
    chk("R7 two operands x one slot", 32'(cmp_count), 2);
    tick();
    chk("R3 slot0 wakes operand A", 32'(cmp_on), 32'h0080);
    bcast(2'b00, 9, 9);
    chk("R4 unqualified slot no count", 32'(cmp_count), 0);
    tick();
    chk("R4 unqualified slot no wake", 32'(cmp_on), 32'h0080);
    bcast(2'b10, 0, 9);
    chk("R7 one operand x one slot", 32'(cmp_count), 1);
    tick();
    chk("R3 slot1 wakes operand B", 32'(cmp_on), 0);
    chk("R5 req entry3", 32'(iss_req), 32'h08);
  endtask

  task automatic t_sticky();
    bcast(2'b11, 33, 44);
    chk("R10 ready operands not compared", 32'(cmp_count), 0);
    tick();
    chk("R10 ready stays", 32'(iss_req), 32'h08);
  endtask

  task automatic t_release();
    rel_en = 1; rel_slot = 3;
    tick();
    chk("R9 released req", 32'(iss_req), 0);
    chk("R9 released cmp_on", 32'(cmp_on), 0);
  endtask

  task automatic t_bypass();
    alloc(0, 12, 13, 0, 0);
    bcast(2'b11, 13, 12);
    chk("R8 allocating entry not counted", 32'(cmp_count), 0);
    tick();
    chk("R8 same-cycle wake req", 32'(iss_req), 32'h01);
    chk("R8 same-cycle wake cmp_on", 32'(cmp_on), 0);
  endtask

  task automatic t_alloc_ready();
    alloc(5, 1, 2, 1, 1);
    tick();
    chk("R2 preset ready req", 32'(iss_req), 32'h21);
  endtask

  task automatic t_rel_and_alloc();
    rel_en = 1; rel_slot = 5;
    alloc(5, 1, 2, 0, 0);
    tick();
    chk("R9 alloc wins req", 32'(iss_req), 32'h01);
    chk("R9 alloc wins cmp_on", 32'(cmp_on), 32'h0C00);
    bcast(2'b11, 40, 41);
    chk("R7 two operands x two slots", 32'(cmp_count), 4);
    tick();
    chk("R3 mismatch keeps waiting", 32'(cmp_on), 32'h0C00);
  endtask

  task automatic t_multi();
    alloc(7, 20, 20, 0, 0);
    tick();
    chk("R6 entries 5 and 7 waiting", 32'(cmp_on), 32'hCC00);
    bcast(2'b11, 20, 1);
    chk("R7 four operands x two slots", 32'(cmp_count), 8);
    tick();
    chk("R3 multi wake req", 32'(iss_req), 32'h81);
    chk("R3 multi wake cmp_on", 32'(cmp_on), 32'h0800);
  endtask

  initial begin
    idle();
    rst_n = 0;
    @(negedge clk);
    t_reset();
    t_wakeup();
    t_sticky();
    t_release();
    t_bypass();
    t_alloc_ready();
    t_rel_and_alloc();
    t_multi();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule